// File: doc/BRIEF.md
# Eight-Bit Port Expander Register Core

This block holds the registers and pin logic of an eight-bit general-purpose I/O port. It sits behind a serial-bus slave, which gives it a small parallel register interface: a two-bit register select, a write strobe with data, and a read strobe with combinational read data. On the pin side it takes eight raw input samples. It drives eight output values and eight per-pin output enables, and it raises an active-low interrupt when an input changes.

Four registers can be addressed:

| Address | Register | Access |
|---|---|---|
| 0 | Input view | Read-only |
| 1 | Output drive | Read/write |
| 2 | Read-inversion mask | Read/write |
| 3 | Direction | Read/write |

A direction bit of 1 makes its pin an input, with the output enable off. A 0 makes the pin drive the matching output-drive bit. Inputs pass through a two-flop synchronizer. Each read of the input view records a snapshot of the synchronized pins. The interrupt flags any input-direction pin that no longer matches that snapshot.

Top module: `pinbank_core`

## Requirements
- R1: After reset, the output-drive register is FFh, the inversion mask is 00h and the direction register is FFh. As a result, pinOe is 00h and pinOut is FFh.
- R2: A write at address 1, 2 or 3 loads that register at the clock edge that carries the write strobe. A read at the same address then returns the written value unchanged.
- R3: A write at address 0 changes no register. Reads of addresses 1 to 3, pinOut and pinOe all keep their values.
- R4: pinOut bit i equals output-drive bit i. pinOe bit i is 1 exactly when direction bit i is 0.
- R5: A read at address 0 returns the synchronized pins XORed bit by bit with the inversion mask. A change on pinIn becomes visible after two rising clock edges.
- R6: irqN is 0 exactly when some pin whose direction bit is 1 has a synchronized value that differs from the last snapshot. Pins whose direction bit is 0 never affect irqN.
- R7: A read at address 0 stores the synchronized pins, without inversion, as the new snapshot at that clock edge. The interrupt then clears unless the pins change again. The interrupt also clears when the pins return to the snapshot value.
- R8: A read at address 1, 2 or 3 leaves the snapshot unchanged, so a pending interrupt stays asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Register select |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe (snapshot when address is 0) |
| rdData | output | 8 | Read data for regAddr |
| pinIn | input | 8 | Raw pin samples |
| pinOut | output | 8 | Output drive values |
| pinOe | output | 8 | Per-pin output enables |
| irqN | output | 1 | Active-low change interrupt |

## Verification
Every register is written with all 256 values. Each value is read back and compared against pinOut or the inverse of pinOe. This separates the three write paths and exposes any stuck or swapped bit.

The inversion mask is swept against several pin patterns. These patterns show whether the XOR is applied per bit and only on address 0.

All 256 direction settings are also paired with a pin change that differs per setting. For each pair the bench predicts irqN from the changed bits masked by the direction. This separates input pins from output pins. Follow-up steps of return-to-snapshot, reading another address, and reading address 0 tell the two clearing paths apart from a non-capturing read.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_INPUT  = 2'd0,
    SEL_DRIVE  = 2'd1,
    SEL_INVERT = 2'd2,
    SEL_DIR    = 2'd3
  } regSel_e;

  typedef struct packed {
    logic loadDrive;
    logic loadInvert;
    logic loadDir;
    logic snapInput;
  } ctrlStrobes_t;
endpackage

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  output ctrlStrobes_t      strobes,
  output regSel_e           rdSel
);
  regSel_e sel;

  assign sel = regSel_e'(regAddr);
  assign rdSel = sel;

  always_comb begin
    strobes = '0;
    if (wrEn) begin
      unique case (sel)
        SEL_DRIVE:  strobes.loadDrive  = 1'b1;
        SEL_INVERT: strobes.loadInvert = 1'b1;
        SEL_DIR:    strobes.loadDir    = 1'b1;
        default:    ;
      endcase
    end
    strobes.snapInput = rdEn && (sel == SEL_INPUT);
  end

  // R3: writes aimed at the input view raise no load strobe
  a_r3_addr0_no_load: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == 2'd0) |-> !(strobes.loadDrive || strobes.loadInvert || strobes.loadDir));

  // R2: at most one register is loaded per write
  a_r2_single_load: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.loadDrive, strobes.loadInvert, strobes.loadDir}));
endmodule

// File: rtl/pinbank_datapath.sv
module pinbank_datapath
  import pinbank_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  regSel_e          rdSel,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  output logic             irqN
);
  localparam logic [WIDTH-1:0] DRIVE_RST  = '1;
  localparam logic [WIDTH-1:0] INVERT_RST = '0;
  localparam logic [WIDTH-1:0] DIR_RST    = '1;

  logic [SYNC_STAGES-1:0][WIDTH-1:0] syncChain;
  logic [WIDTH-1:0] syncPins;
  logic [WIDTH-1:0] driveReg, invertReg, dirReg, snapReg;
  logic [WIDTH-1:0] changed;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[s] <= '0;
        else if (s == 0) syncChain[s] <= pinIn;
        else syncChain[s] <= syncChain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncPins = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      driveReg  <= DRIVE_RST;
      invertReg <= INVERT_RST;
      dirReg    <= DIR_RST;
      snapReg   <= '0;
    end else begin
      if (strobes.loadDrive)  driveReg  <= wrData;
      if (strobes.loadInvert) invertReg <= wrData;
      if (strobes.loadDir)    dirReg    <= wrData;
      if (strobes.snapInput)  snapReg   <= syncPins;
    end
  end

  always_comb begin
    unique case (rdSel)
      SEL_INPUT:  rdData = syncPins ^ invertReg;
      SEL_DRIVE:  rdData = driveReg;
      SEL_INVERT: rdData = invertReg;
      SEL_DIR:    rdData = dirReg;
      default:    rdData = '0;
    endcase
  end

  assign pinOut  = driveReg;
  assign pinOe   = ~dirReg;
  assign changed = (syncPins ^ snapReg) & dirReg;
  assign irqN    = ~|changed;

  // R2: registers hold when their load strobe is idle
  a_r2_drive_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadDrive |=> $stable(driveReg));
  a_r2_invert_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadInvert |=> $stable(invertReg));
  a_r2_dir_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadDir |=> $stable(dirReg));

  // R7: a snapshot read records the synchronized pins
  a_r7_snap_capture: assert property (@(posedge clk) disable iff (!rstN)
    strobes.snapInput |=> snapReg == $past(syncPins));

  // R8: no snapshot strobe, no snapshot change
  a_r8_snap_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.snapInput |=> $stable(snapReg));
endmodule

// File: rtl/pinbank_core.sv
module pinbank_core
  import pinbank_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regAddr,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  output logic             irqN
);
  ctrlStrobes_t strobes;
  regSel_e      rdSel;

  pinbank_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  pinbank_datapath #(
    .WIDTH       (WIDTH),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .rdSel    (rdSel),
    .wrData   (wrData),
    .pinIn    (pinIn),
    .rdData   (rdData),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .irqN     (irqN)
  );
endmodule

// File: tb/pinbank_core_bench.sv
`timescale 1ns/1ps
module pinbank_core_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic [7:0] pinIn = '0;
  logic [7:0] pinOut;
  logic [7:0] pinOe;
  logic       irqN;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  pinbank_core u_pinbank_core (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .irqN(irqN)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    regAddr = a; wrData = d; wrEn = 1'b1;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1 d = rdData;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    regAddr = a; rdEn = 1'b1;
    #1 d = rdData;
    tick();
    rdEn = 1'b0;
  endtask

  task automatic setPins(input logic [7:0] p);
    pinIn = p;
    tick();
    tick();
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [7:0] d;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    #1;
    check("R1 pinOe", pinOe, 8'h00);
    check("R1 pinOut", pinOut, 8'hFF);
    peek(2'd1, d); check("R1 drive", d, 8'hFF);
    peek(2'd2, d); check("R1 invert", d, 8'h00);
    peek(2'd3, d); check("R1 dir", d, 8'hFF);
    @(negedge clk);

    // R2/R4 exhaustive register sweeps
    for (int v = 0; v < 256; v++) begin
      writeReg(2'd1, 8'(v));
      peek(2'd1, d); check("R2 drive readback", d, 8'(v));
      check("R4 pinOut", pinOut, 8'(v));
      writeReg(2'd3, 8'(v));
      peek(2'd3, d); check("R2 dir readback", d, 8'(v));
      check("R4 pinOe", pinOe, ~8'(v));
      writeReg(2'd2, 8'(v));
      peek(2'd2, d); check("R2 invert readback", d, 8'(v));
      @(negedge clk);
    end

    // R3 writes to address 0 are ignored
    writeReg(2'd1, 8'h5A);
    writeReg(2'd2, 8'h3C);
    writeReg(2'd3, 8'h96);
    for (int v = 0; v < 256; v += 15) begin
      writeReg(2'd0, 8'(v));
      peek(2'd1, d); check("R3 drive kept", d, 8'h5A);
      peek(2'd2, d); check("R3 invert kept", d, 8'h3C);
      peek(2'd3, d); check("R3 dir kept", d, 8'h96);
      check("R3 pinOut kept", pinOut, 8'h5A);
      check("R3 pinOe kept", pinOe, 8'h69);
      @(negedge clk);
    end

    // R5 inversion and two-edge latency
    for (int m = 0; m < 256; m += 17) begin
      writeReg(2'd2, 8'(m));
      for (int k = 0; k < 6; k++) begin
        logic [7:0] p, old;
        peek(2'd0, old);
        old = old ^ 8'(m);
        p = 8'(k * 73 + m + 1);
        pinIn = p;
        tick();
        peek(2'd0, d); check("R5 one edge old", d, old ^ 8'(m));
        @(negedge clk);
        peek(2'd0, d); check("R5 inverted view", d, p ^ 8'(m));
        @(negedge clk);
      end
    end
    writeReg(2'd2, 8'h00);

    // R6/R7/R8 interrupt over all direction settings
    for (int c = 0; c < 256; c++) begin
      logic [7:0] p0, p1;
      p0 = 8'(c * 29 + 7);
      p1 = p0 ^ 8'(c * 37 + 1);
      writeReg(2'd3, 8'(c));
      setPins(p0);
      readReg(2'd0, d);
      #1 check("R7 irq clear after read", {7'd0, irqN}, 8'd1);
      @(negedge clk);
      setPins(p1);
      #1 check("R6 irq vs masked change", {7'd0, irqN},
               {7'd0, ((p0 ^ p1) & 8'(c)) == 8'd0});
      @(negedge clk);
      readReg(2'd3, d);
      #1 check("R8 other read keeps irq", {7'd0, irqN},
               {7'd0, ((p0 ^ p1) & 8'(c)) == 8'd0});
      @(negedge clk);
      setPins(p0);
      #1 check("R7 irq clears on return", {7'd0, irqN}, 8'd1);
      @(negedge clk);
      setPins(p1);
      readReg(2'd0, d);
      check("R5 read value", d, p1);
      #1 check("R7 irq clears on snapshot", {7'd0, irqN}, 8'd1);
      @(negedge clk);
    end

    finishRun();
  end
endmodule